// File: doc/BRIEF.md
# Alternating-Compare PWM Timer Channel

This block is a single 16-bit timer channel. A prescaler divides the system clock into count ticks, and a counter steps up or down on each tick. Two compare registers are checked against the counter, and a one-bit output flag is driven from the compare matches according to a selectable output mode. The flag reaches the output pin through a polarity inverter and an enable gate. Software can also set the flag directly at any time with a force write.

The main use is hardware PWM. In alternating mode the channel matches compare 1 and compare 2 in turn. Compare 1 sets the length of the low phase and compare 2 sets the length of the high phase. On each match the output flag toggles and the counter restarts from the load value. Each compare register can be refilled from its own preload register when the other compare register matches. Software can therefore change the duty cycle on the fly by writing only the preloads, with no cycle-exact timing needed.

Four sticky event flags record terminal compares, overflows and the two individual compare matches. Each flag has an interrupt enable, and the interrupt output is the OR of the enabled flags.

Top module: `alt_pwm_timer`

## Requirements
- R1: After reset every register reads 0 and pin, pin_oe and irq are low. The register addresses are: 0 compare 1, 1 compare 2, 2 preload 1, 3 preload 2, 4 load value, 5 counter (a write sets the count and restarts the alternation at compare 1), 6 control, 7 status.
- R2: While control bit 0 (run) is 1, the counter advances once every 2^p clocks, where p is control bits [11:10].
- R3: While run is 0, the counter holds its value.
- R4: With control bit 2 (length) set, the counter reloads the load value on a terminal match instead of stepping. When counting up (control bit 1 = 0) the terminal match is with compare 1. When counting down (control bit 1 = 1) it is with compare 2.
- R5: Without a reload, counting up past all-ones wraps to 0, and counting down past 0 wraps to all-ones. Either wrap sets the overflow flag (status bit 1).
- R6: In alternating mode (control bits [4:3] = 2) with the length bit set, the load value 1 and both compares nonzero, the flag is low for compare-1 ticks and high for compare-2 ticks. The period is the sum of the two compare values.
- R7: In alternating mode, a phase whose compare value is 0 is skipped without a toggle. A zero compare 2 holds the flag low (0% duty), and a zero compare 1 holds it high (100% duty), with no pulse at any period boundary.
- R8: With control bit 9 set, a compare-1 match loads compare 2 from preload 2, and a compare-2 match loads compare 1 from preload 1.
- R9: In toggle mode (control bits [4:3] = 1) the flag inverts on every terminal match.
- R10: The pin equals the flag XOR control bit 5 (invert) while control bit 6 (output enable) is 1. Otherwise the pin is 0. pin_oe follows control bit 6.
- R11: A control write with bit 7 set loads the flag with bit 8 at that clock edge, whatever the mode. Bit 7 always reads back as 0.
- R12: The status flags are sticky. Bit 0 is terminal compare, bit 1 is overflow, bit 2 is compare-1 match and bit 3 is compare-2 match. A status write clears each flag written as 0 and keeps each flag written as 1. An event in the same cycle as a clearing write leaves the flag set.
- R13: Status bits [7:4] are the enables for flags [3:0], and irq is the OR of each flag ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| pin | output | 1 | Output flag after the invert and enable stages |
| pin_oe | output | 1 | Output driver enable |
| irq | output | 1 | Interrupt request |

## Verification
A hardware compare event and a software write to the status register that clears the same flag can land on the same clock edge. The bench provokes this by starting the counter at a known value with compare 1 set to 4. It then counts clocks so that a write of all zeros to the status register hits exactly the edge at which the counter reaches 4. The status register is read back right afterwards and must still show the terminal and compare-1 flags. A later clearing write, on an edge with no event, must read back as zero.

// File: rtl/alt_pwm_pkg.sv
package alt_pwm_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int PRESC_W = 2;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_ALT    = 2'd2,
        OM_SPARE  = 2'd3
    } outmode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CMP1 = 3'd0,
        RA_CMP2 = 3'd1,
        RA_PRE1 = 3'd2,
        RA_PRE2 = 3'd3,
        RA_LOAD = 3'd4,
        RA_CNT  = 3'd5,
        RA_CTRL = 3'd6,
        RA_STAT = 3'd7
    } regaddr_e;

    typedef struct packed {
        logic [3:0]         spare;
        logic [PRESC_W-1:0] presc;
        logic               reload;
        logic               force_val;
        logic               force_go;
        logic               oen;
        logic               invert;
        outmode_e           mode;
        logic               length;
        logic               down;
        logic               run;
    } ctrl_t;

    typedef struct packed {
        logic cmp2;
        logic cmp1;
        logic ovf;
        logic term;
    } evt_t;

    function automatic evt_t sticky_next(evt_t cur, evt_t set, logic wr, evt_t keep);
        evt_t base;
        base = wr ? evt_t'(cur & keep) : cur;
        return evt_t'(base | set);
    endfunction

endpackage

// File: rtl/alt_pwm_prescale.sv
module alt_pwm_prescale
    import alt_pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [PRESC_W-1:0] sel,
    output logic               tick
);
    localparam int PC_W = (1 << PRESC_W) - 1;

    logic [PC_W-1:0] pcnt;
    logic [PC_W:0]   one_sh;
    logic [PC_W-1:0] mask;

    always_comb begin
        one_sh = (PC_W+1)'(1) << sel;
        mask   = PC_W'(one_sh - 1'b1);
    end

    assign tick = run && ((pcnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/alt_pwm_count.sv
module alt_pwm_count
    import alt_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             down,
    input  logic             length,
    input  logic             alt,
    input  logic [CNT_W-1:0] cmp1,
    input  logic [CNT_W-1:0] cmp2,
    input  logic [CNT_W-1:0] load,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             sel,
    output evt_t             evt,
    output logic             step
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic z1, z2, reinit;

    always_comb begin
        z1 = (cmp1 == '0);
        z2 = (cmp2 == '0);
        if (alt) begin
            evt.cmp1 = tick && !sel && ((cnt == cmp1) || z1);
            evt.cmp2 = tick &&  sel && ((cnt == cmp2) || z2);
            evt.term = evt.cmp1 || evt.cmp2;
        end else begin
            evt.cmp1 = tick && (cnt == cmp1);
            evt.cmp2 = tick && (cnt == cmp2);
            evt.term = down ? evt.cmp2 : evt.cmp1;
        end
        // an empty following phase is absorbed: no toggle, select stays
        step     = alt && ((evt.cmp1 && !z2) || (evt.cmp2 && !z1));
        reinit   = evt.term && length;
        evt.ovf  = tick && !reinit && (down ? (cnt == '0) : (cnt == TOP));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sel <= 1'b0;
        end else if (cnt_wr) begin
            cnt <= cnt_wdata;
            sel <= 1'b0;
        end else if (tick) begin
            if (reinit)    cnt <= load;
            else if (down) cnt <= cnt - 1'b1;
            else           cnt <= cnt + 1'b1;
            sel <= sel ^ step;
        end
    end
endmodule

// File: rtl/alt_pwm_oflag.sv
module alt_pwm_oflag
    import alt_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  outmode_e mode,
    input  logic     term,
    input  logic     step,
    input  logic     force_go,
    input  logic     force_val,
    output logic     flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (force_go) begin
            flag <= force_val;
        end else begin
            unique case (mode)
                OM_TOGGLE: if (term) flag <= ~flag;
                OM_ALT:    if (step) flag <= ~flag;
                default:   flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/alt_pwm_timer.sv
module alt_pwm_timer
    import alt_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pin,
    output logic              pin_oe,
    output logic              irq
);
    logic [CNT_W-1:0] cmp1_q, cmp2_q, pre1_q, pre2_q, load_q, cnt;
    ctrl_t            ctrl_q, wctl;
    evt_t             flg_q, en_q, evt;
    logic             tick, sel, step, flag, force_go, cnt_wr, stat_wr;

    assign wctl     = ctrl_t'(wr_data);
    assign cnt_wr   = wr_en && (wr_addr == RA_CNT);
    assign stat_wr  = wr_en && (wr_addr == RA_STAT);
    assign force_go = wr_en && (wr_addr == RA_CTRL) && wctl.force_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp1_q <= '0;
            cmp2_q <= '0;
            pre1_q <= '0;
            pre2_q <= '0;
            load_q <= '0;
            ctrl_q <= '0;
            flg_q  <= '0;
            en_q   <= '0;
        end else begin
            // software write takes priority over a preload transfer
            if (wr_en && wr_addr == RA_CMP1)      cmp1_q <= wr_data[CNT_W-1:0];
            else if (ctrl_q.reload && evt.cmp2)   cmp1_q <= pre1_q;
            if (wr_en && wr_addr == RA_CMP2)      cmp2_q <= wr_data[CNT_W-1:0];
            else if (ctrl_q.reload && evt.cmp1)   cmp2_q <= pre2_q;
            if (wr_en && wr_addr == RA_PRE1)      pre1_q <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == RA_PRE2)      pre2_q <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == RA_LOAD)      load_q <= wr_data[CNT_W-1:0];
            if (wr_en && wr_addr == RA_CTRL) begin
                ctrl_q          <= wctl;
                ctrl_q.force_go <= 1'b0;
                ctrl_q.spare    <= '0;
            end
            flg_q <= sticky_next(flg_q, evt, stat_wr, evt_t'(wr_data[3:0]));
            if (stat_wr) en_q <= evt_t'(wr_data[7:4]);
        end
    end

    alt_pwm_prescale u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .sel  (ctrl_q.presc),
        .tick (tick)
    );

    alt_pwm_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .down      (ctrl_q.down),
        .length    (ctrl_q.length),
        .alt       (ctrl_q.mode == OM_ALT),
        .cmp1      (cmp1_q),
        .cmp2      (cmp2_q),
        .load      (load_q),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (wr_data[CNT_W-1:0]),
        .cnt       (cnt),
        .sel       (sel),
        .evt       (evt),
        .step      (step)
    );

    alt_pwm_oflag u_oflag (
        .clk       (clk),
        .rst       (rst),
        .mode      (ctrl_q.mode),
        .term      (evt.term),
        .step      (step),
        .force_go  (force_go),
        .force_val (wctl.force_val),
        .flag      (flag)
    );

    always_comb begin
        unique case (regaddr_e'(rd_addr))
            RA_CMP1: rd_data = DATA_W'(cmp1_q);
            RA_CMP2: rd_data = DATA_W'(cmp2_q);
            RA_PRE1: rd_data = DATA_W'(pre1_q);
            RA_PRE2: rd_data = DATA_W'(pre2_q);
            RA_LOAD: rd_data = DATA_W'(load_q);
            RA_CNT:  rd_data = DATA_W'(cnt);
            RA_CTRL: rd_data = ctrl_q;
            default: rd_data = DATA_W'({en_q, flg_q});
        endcase
    end

    assign irq    = |(flg_q & en_q);
    assign pin_oe = ctrl_q.oen;
    assign pin    = ctrl_q.oen & (flag ^ ctrl_q.invert);
endmodule

// File: rtl/alt_pwm_timer_chk.sv
module alt_pwm_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run,
    input logic             down,
    input logic             length,
    input logic             alt,
    input logic             term,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load,
    input logic             sel,
    input logic             flag,
    input logic             force_go,
    input logic             force_val,
    input logic             stat_wr,
    input logic [3:0]       flg
);
    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));

    assert_reinit_load_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && term && length && !cnt_wr) |=> (cnt == $past(load)));

    assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !down && !cnt_wr && (&cnt) && !(term && length)) |=> ((cnt == '0) && flg[1]));

    assert_alt_lockstep_R6: assert property (@(posedge clk) disable iff (rst)
        (alt && !force_go && !cnt_wr) |=> ((flag ^ $past(flag)) == (sel ^ $past(sel))));

    assert_force_load_R11: assert property (@(posedge clk) disable iff (rst)
        force_go |=> (flag == $past(force_val)));

    assert_flags_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((flg & $past(flg)) == $past(flg)));
endmodule

bind alt_pwm_timer alt_pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .run       (ctrl_q.run),
    .down      (ctrl_q.down),
    .length    (ctrl_q.length),
    .alt       (ctrl_q.mode == alt_pwm_pkg::OM_ALT),
    .term      (evt.term),
    .cnt_wr    (cnt_wr),
    .cnt       (cnt),
    .load      (load_q),
    .sel       (sel),
    .flag      (flag),
    .force_go  (force_go),
    .force_val (wctl.force_val),
    .stat_wr   (stat_wr),
    .flg       (flg_q)
);

// File: tb/alt_pwm_timer_bench.sv
module alt_pwm_timer_bench;
    import alt_pwm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CT_RUN  = 16'h0001;
    localparam logic [15:0] CT_DOWN = 16'h0002;
    localparam logic [15:0] CT_LEN  = 16'h0004;
    localparam logic [15:0] CT_TOG  = 16'h0008;
    localparam logic [15:0] CT_ALT  = 16'h0010;
    localparam logic [15:0] CT_INV  = 16'h0020;
    localparam logic [15:0] CT_OEN  = 16'h0040;
    localparam logic [15:0] CT_FGO  = 16'h0080;
    localparam logic [15:0] CT_FVAL = 16'h0100;
    localparam logic [15:0] CT_RLD  = 16'h0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pin, pin_oe, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    alt_pwm_timer u_alt_pwm_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin(pin), .pin_oe(pin_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic halt_clear();
        wr(RA_CTRL, 16'h0);
        wr(RA_CTRL, CT_FGO);
        wr(RA_STAT, 16'h0);
    endtask

    task automatic pwm_start(input int c1, input int c2, input logic [15:0] extra);
        halt_clear();
        wr(RA_CMP1, 16'(c1)); wr(RA_CMP2, 16'(c2));
        wr(RA_PRE1, 16'(c1)); wr(RA_PRE2, 16'(c2));
        wr(RA_LOAD, 16'd1);   wr(RA_CNT, 16'd1);
        wr(RA_CTRL, CT_RUN | CT_LEN | CT_ALT | CT_RLD | extra);
    endtask

    task automatic measure(input int n, output int highs, output int trans);
        logic prev;
        prev = pin; highs = 0; trans = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin) highs++;
            if (pin != prev) trans++;
            prev = pin;
        end
    endtask

    initial begin
        logic [15:0] v, v2;
        int hi, tr;
        @(negedge clk);
        idle(3);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", {16'h0, v}, 32'h0);
        end
        chk("R1 reset pin", {31'h0, pin}, 32'h0);
        chk("R1 reset pin_oe", {31'h0, pin_oe}, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // R2 prescaler sweep, then R3 stop
        for (int p = 0; p < 4; p++) begin
            halt_clear();
            wr(RA_CMP1, 16'hFFFF); wr(RA_CMP2, 16'hFFFF); wr(RA_CNT, 16'h0);
            wr(RA_CTRL, CT_RUN | 16'(p << 10));
            idle(16);
            rd(RA_CNT, v);
            chk($sformatf("R2 prescale p=%0d", p), {16'h0, v}, 32'(16 >> p));
        end
        wr(RA_CTRL, 16'h0);
        rd(RA_CNT, v);
        idle(5);
        rd(RA_CNT, v2);
        chk("R3 stopped counter holds", {16'h0, v2}, {16'h0, v});

        // R4 up count with reinit, R9 toggle output
        halt_clear();
        wr(RA_CMP1, 16'd5); wr(RA_CMP2, 16'hFFFF); wr(RA_LOAD, 16'd1); wr(RA_CNT, 16'd1);
        wr(RA_CTRL, CT_RUN | CT_LEN | CT_TOG | CT_OEN);
        idle(13);
        rd(RA_CNT, v);
        chk("R4 up reinit count", {16'h0, v}, 32'd4);
        chk("R9 toggle after two matches", {31'h0, pin}, 32'd0);
        rd(RA_STAT, v);
        chk("R12 flags term+cmp1", {28'h0, v[3:0]}, 32'h5);
        idle(4);
        rd(RA_CNT, v);
        chk("R4 up reinit count later", {16'h0, v}, 32'd3);
        chk("R9 toggle after three matches", {31'h0, pin}, 32'd1);

        // R4 down count terminal on compare 2
        halt_clear();
        wr(RA_CMP1, 16'hFFFF); wr(RA_CMP2, 16'd2); wr(RA_LOAD, 16'd6); wr(RA_CNT, 16'd6);
        wr(RA_CTRL, CT_RUN | CT_DOWN | CT_LEN);
        idle(7);
        rd(RA_CNT, v);
        chk("R4 down reinit count", {16'h0, v}, 32'd4);
        rd(RA_STAT, v);
        chk("R4 down flags term+cmp2", {28'h0, v[3:0]}, 32'h9);

        // R5 overflow both directions
        halt_clear();
        wr(RA_CMP1, 16'd5); wr(RA_CMP2, 16'd5); wr(RA_CNT, 16'hFFFE);
        wr(RA_CTRL, CT_RUN);
        idle(3);
        rd(RA_CNT, v);
        chk("R5 up wrap count", {16'h0, v}, 32'd1);
        rd(RA_STAT, v);
        chk("R5 up wrap flag", {28'h0, v[3:0]}, 32'h2);
        halt_clear();
        wr(RA_CNT, 16'd1);
        wr(RA_CTRL, CT_RUN | CT_DOWN);
        idle(2);
        rd(RA_CNT, v);
        chk("R5 down wrap count", {16'h0, v}, 32'hFFFF);
        rd(RA_STAT, v);
        chk("R5 down wrap flag", {28'h0, v[3:0]}, 32'h2);

        // R12 event coincides with clearing write; R13 irq
        halt_clear();
        wr(RA_CMP1, 16'd4); wr(RA_CMP2, 16'hFFFF); wr(RA_LOAD, 16'd1); wr(RA_CNT, 16'd1);
        wr(RA_CTRL, CT_RUN | CT_LEN);
        idle(3);
        wr(RA_STAT, 16'h0);
        rd(RA_STAT, v);
        chk("R12 set wins over clear", {16'h0, v}, 32'h5);
        wr(RA_CTRL, 16'h0);
        wr(RA_STAT, 16'h1);
        rd(RA_STAT, v);
        chk("R12 write one keeps", {16'h0, v}, 32'h1);
        chk("R13 irq without enable", {31'h0, irq}, 32'd0);
        wr(RA_STAT, 16'h11);
        chk("R13 irq enabled flag", {31'h0, irq}, 32'd1);
        wr(RA_STAT, 16'h81);
        chk("R13 irq other enable only", {31'h0, irq}, 32'd0);
        wr(RA_STAT, 16'h0);
        rd(RA_STAT, v);
        chk("R12 clear on write zero", {16'h0, v}, 32'h0);

        // R11 force
        halt_clear();
        wr(RA_CTRL, CT_OEN | CT_FGO | CT_FVAL);
        chk("R11 force high", {31'h0, pin}, 32'd1);
        wr(RA_CTRL, CT_OEN);
        chk("R11 forced value held", {31'h0, pin}, 32'd1);
        rd(RA_CTRL, v);
        chk("R11 force bit reads zero", {31'h0, v[7]}, 32'd0);
        wr(RA_CTRL, CT_OEN | CT_FGO);
        chk("R11 force low", {31'h0, pin}, 32'd0);

        // R6 / R7 alternating sweep
        for (int c1 = 0; c1 < 5; c1++) begin
            for (int c2 = 0; c2 < 5; c2++) begin
                int per, win, ehi, etr;
                string tag;
                per = c1 + c2;
                win = (per == 0) ? 8 : per;
                tag = (c1 == 0 || c2 == 0) ? "R7" : "R6";
                pwm_start(c1, c2, CT_OEN);
                idle(3 * per + 6);
                measure(win, hi, tr);
                ehi = (per == 0) ? 0 : c2;
                etr = (c1 != 0 && c2 != 0) ? 2 : 0;
                chk($sformatf("%s high ticks c1=%0d c2=%0d", tag, c1, c2), 32'(hi), 32'(ehi));
                chk($sformatf("%s edges c1=%0d c2=%0d", tag, c1, c2), 32'(tr), 32'(etr));
            end
        end

        // R8 preload transfer changes duty
        pwm_start(3, 2, CT_OEN);
        idle(12);
        wr(RA_PRE1, 16'd1); wr(RA_PRE2, 16'd4);
        idle(20);
        measure(5, hi, tr);
        chk("R8 new high ticks", 32'(hi), 32'd4);
        chk("R8 new edges", 32'(tr), 32'd2);
        rd(RA_CMP1, v);
        chk("R8 compare 1 refilled", {16'h0, v}, 32'd1);

        // R10 polarity and enable
        pwm_start(2, 3, CT_OEN | CT_INV);
        idle(20);
        measure(5, hi, tr);
        chk("R10 inverted high ticks", 32'(hi), 32'd2);
        pwm_start(2, 3, 16'h0);
        idle(20);
        measure(5, hi, tr);
        chk("R10 disabled pin low", 32'(hi), 32'd0);
        chk("R10 pin_oe low", {31'h0, pin_oe}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule